// File: doc/BRIEF.md
# DDR Data-Phase Burst Sequencer

This block times the data phase of DDR SDRAM transfers after a separate command scheduler has put a column command on the bus. On a read it lets the programmed CAS latency pass, then raises a read-capture enable for exactly as many clocks as the burst occupies. The input capture registers and the read FIFO use that enable. On a write it opens the strobe drivers one clock early to form the preamble and then drives write data, strobe enable and byte masks for the burst. After the last write beat it waits out the write-recovery time. When a transfer is finished it sends a one-clock completion pulse back to the scheduler.

The scheduler signals queued work on two pending flags, one for reads and one for writes. The sequencer samples them only at decision points: while idle, during the completion cycle, and on the final clock of a burst. A pending transfer seen at the end of a burst chains straight on without passing through idle. The memory data path is half as wide as the system word, so each clock of a burst carries two beats. The upper half of the word goes out on the rising edge and the lower half on the falling edge. Read beats are packed back into a full word in the same order.

Top module: `ddr_burst_seq`

## Requirements
- R1: While reset is asserted and right after it, every enable, `xfer_done`, `rd_word_vld`, the write data and the masks are 0.
- R2: `pend_rd` and `pend_wr` are sampled only in idle, in the completion cycle and in the final clock of a burst. A flag that is high only at other times has no effect. When both flags are sampled high, the read is taken.
- R3: A read accepted from idle, from completion or after a write burst raises `read_data_en` after 2 clocks of latency wait when `cas_sel3`=0, or after 3 clocks when `cas_sel3`=1. `cas_sel3` is sampled on the accepting edge.
- R4: `read_data_en` is high for exactly BURST_BEATS/2 consecutive clocks per read burst and never together with `write_data_en`.
- R5: A read pending at the end of a read burst starts its burst on the next clock, so `read_data_en` stays high without a gap.
- R6: A write accepted from idle, completion or a read burst spends one preamble clock and then holds `write_data_en` for BURST_BEATS/2 clocks. A write pending at the end of a write burst continues with no preamble.
- R7: `write_dqs_en` is high in the preamble clock and in every clock where `write_data_en` is high, and is low otherwise.
- R8: While `write_data_en` is high: `dq_rise` = `wr_word[BUS_W-1:BUS_W/2]`, `dq_fall` = the lower half, `dm_rise` = inverted `wr_be[BUS_W/8-1:BUS_W/16]`, `dm_fall` = inverted lower half of `wr_be` (`wr_be` bit i enables byte i, byte 0 in bits 7:0). Otherwise all four are 0.
- R9: After a write burst with nothing pending, `xfer_done` rises TWR_CYC+1 clocks after the last `write_data_en` clock. A read pending at write end skips recovery.
- R10: `xfer_done` is a single-clock pulse. It comes one clock after a read burst that has nothing pending, and a flag sampled during it starts a new transfer at once.
- R11: For each clock with `read_data_en` high, the next clock shows `rd_word` = {`rd_rise`,`rd_fall`} with `rd_word_vld` high. `rd_word` holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_sel3 | input | 1 | 0 selects CAS latency 2, 1 selects 3 |
| pend_rd | input | 1 | Scheduler has a read column command outstanding |
| pend_wr | input | 1 | Scheduler has a write column command outstanding |
| wr_word | input | BUS_W | Write data word for the current burst clock |
| wr_be | input | BUS_W/8 | Byte enables for `wr_word`, 1 = write byte |
| rd_rise | input | BUS_W/2 | Captured rising-edge read beat |
| rd_fall | input | BUS_W/2 | Captured falling-edge read beat |
| read_data_en | output | 1 | Enable for capture registers and read FIFO |
| write_data_en | output | 1 | Write data output enable |
| write_dqs_en | output | 1 | Data strobe output enable |
| dq_rise | output | BUS_W/2 | Write beat for the rising edge |
| dq_fall | output | BUS_W/2 | Write beat for the falling edge |
| dm_rise | output | BUS_W/16 | Data mask for the rising beat |
| dm_fall | output | BUS_W/16 | Data mask for the falling beat |
| rd_word | output | BUS_W | Reassembled read word |
| rd_word_vld | output | 1 | `rd_word` updated this clock |
| xfer_done | output | 1 | Completion pulse to the scheduler |

## Verification
The bench goes after the latency count at both CAS settings. A one-off timer would start read capture a clock early or late and catch the wrong beats. It also exercises back-to-back chaining of reads, of writes and of mixed pairs. A sequencer that dropped through idle would leave a gap in `read_data_en` or insert a second write preamble. Recovery is measured from the last write clock to the completion pulse, since a short wait would let the scheduler precharge too soon. The bench also pulses the pending flags between decision points and raises both at once, to expose a design that starts spurious writes or gives writes priority.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_CASWAIT = 3'd1,
    SQ_RDBURST = 3'd2,
    SQ_WRPRE   = 3'd3,
    SQ_WRBURST = 3'd4,
    SQ_RECOVER = 3'd5,
    SQ_DONE    = 3'd6
  } seq_state_t;

endpackage

// File: rtl/ddr_seq_timer.sv
module ddr_seq_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = load | (run & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (run)  cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && zero && !load) |=> zero); // R3

endmodule

// File: rtl/ddr_seq_beats.sv
module ddr_seq_beats #(
  parameter int CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic last
);

  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign last = active & (cnt_q == CW'(CYC - 1));

  always_comb begin
    if (!active || last) cnt_d = '0;
    else                 cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(CYC - 1)); // R4

  AST_BEAT_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/ddr_seq_datapath.sv
module ddr_seq_datapath #(
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_active,
  input  logic [BUS_W-1:0]   wr_word,
  input  logic [BUS_W/8-1:0] wr_be,
  input  logic               rd_active,
  input  logic [BUS_W/2-1:0] rd_rise,
  input  logic [BUS_W/2-1:0] rd_fall,
  output logic [BUS_W/2-1:0] dq_rise,
  output logic [BUS_W/2-1:0] dq_fall,
  output logic [BUS_W/16-1:0] dm_rise,
  output logic [BUS_W/16-1:0] dm_fall,
  output logic [BUS_W-1:0]   rd_word,
  output logic               rd_word_vld
);

  localparam int HALF_W = BUS_W / 2;
  localparam int BE_W   = BUS_W / 8;
  localparam int HBE_W  = BE_W / 2;

  logic [BUS_W-1:0] word_q;
  logic             vld_q;

  always_comb begin
    dq_rise = '0;
    dq_fall = '0;
    dm_rise = '0;
    dm_fall = '0;
    if (wr_active) begin
      dq_rise = wr_word[BUS_W-1:HALF_W];
      dq_fall = wr_word[HALF_W-1:0];
      dm_rise = ~wr_be[BE_W-1:HBE_W];
      dm_fall = ~wr_be[HBE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word_q <= '0;
    else if (rd_active) word_q <= {rd_rise, rd_fall};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= rd_active;
  end

  assign rd_word     = word_q;
  assign rd_word_vld = vld_q;

  AST_RD_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active |=> $stable(rd_word)); // R11

endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
  import ddr_seq_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int BURST_BEATS = 2,
  parameter int TWR_CYC     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cas_sel3,
  input  logic                pend_rd,
  input  logic                pend_wr,
  input  logic [BUS_W-1:0]    wr_word,
  input  logic [BUS_W/8-1:0]  wr_be,
  input  logic [BUS_W/2-1:0]  rd_rise,
  input  logic [BUS_W/2-1:0]  rd_fall,
  output logic                read_data_en,
  output logic                write_data_en,
  output logic                write_dqs_en,
  output logic [BUS_W/2-1:0]  dq_rise,
  output logic [BUS_W/2-1:0]  dq_fall,
  output logic [BUS_W/16-1:0] dm_rise,
  output logic [BUS_W/16-1:0] dm_fall,
  output logic [BUS_W-1:0]    rd_word,
  output logic                rd_word_vld,
  output logic                xfer_done
);

  localparam int BURST_CYC = (BURST_BEATS / 2 < 1) ? 1 : BURST_BEATS / 2;
  localparam int TMR_W     = (TWR_CYC > 4) ? $clog2(TWR_CYC) : 2;

  seq_state_t state_q;
  seq_state_t state_d;

  logic             burst_active;
  logic             burst_last;
  logic             tmr_zero;
  logic             tmr_load;
  logic             tmr_run;
  logic [TMR_W-1:0] tmr_val;
  logic [TMR_W-1:0] cas_val;

  // Decision logic: pending flags matter only in idle, done and burst end.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE, SQ_DONE: begin
        if (pend_rd)      state_d = SQ_CASWAIT;
        else if (pend_wr) state_d = SQ_WRPRE;
        else              state_d = SQ_IDLE;
      end
      SQ_CASWAIT: begin
        if (tmr_zero) state_d = SQ_RDBURST;
      end
      SQ_RDBURST: begin
        if (burst_last) begin
          if (pend_rd)      state_d = SQ_RDBURST;
          else if (pend_wr) state_d = SQ_WRPRE;
          else              state_d = SQ_DONE;
        end
      end
      SQ_WRPRE: state_d = SQ_WRBURST;
      SQ_WRBURST: begin
        if (burst_last) begin
          if (pend_rd)      state_d = SQ_CASWAIT;
          else if (pend_wr) state_d = SQ_WRBURST;
          else              state_d = SQ_RECOVER;
        end
      end
      SQ_RECOVER: begin
        if (tmr_zero) state_d = SQ_DONE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  // One shared down-counter times both the CAS wait and write recovery.
  assign cas_val  = cas_sel3 ? TMR_W'(2) : TMR_W'(1);
  assign tmr_load = ((state_d == SQ_CASWAIT) && (state_q != SQ_CASWAIT)) ||
                    ((state_d == SQ_RECOVER) && (state_q != SQ_RECOVER));
  assign tmr_val  = (state_d == SQ_CASWAIT) ? cas_val : TMR_W'(TWR_CYC - 1);
  assign tmr_run  = (state_q == SQ_CASWAIT) || (state_q == SQ_RECOVER);

  ddr_seq_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .zero     (tmr_zero)
  );

  assign burst_active = (state_q == SQ_RDBURST) || (state_q == SQ_WRBURST);

  ddr_seq_beats #(.CYC(BURST_CYC)) u_beats (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (burst_active),
    .last   (burst_last)
  );

  assign read_data_en  = (state_q == SQ_RDBURST);
  assign write_data_en = (state_q == SQ_WRBURST);
  assign write_dqs_en  = (state_q == SQ_WRPRE) || (state_q == SQ_WRBURST);
  assign xfer_done     = (state_q == SQ_DONE);

  ddr_seq_datapath #(.BUS_W(BUS_W)) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_active   (write_data_en),
    .wr_word     (wr_word),
    .wr_be       (wr_be),
    .rd_active   (read_data_en),
    .rd_rise     (rd_rise),
    .rd_fall     (rd_fall),
    .dq_rise     (dq_rise),
    .dq_fall     (dq_fall),
    .dm_rise     (dm_rise),
    .dm_fall     (dm_fall),
    .rd_word     (rd_word),
    .rd_word_vld (rd_word_vld)
  );

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(read_data_en && write_data_en)); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R10

  AST_DQS_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_data_en) |-> $past(write_dqs_en)); // R7

  AST_DQS_COVERS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    write_data_en |-> write_dqs_en); // R7

  AST_CAS_MIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_data_en) |-> ($past(state_q == SQ_CASWAIT, 1) &&
                             $past(state_q == SQ_CASWAIT, 2))); // R3

  AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> ($past(state_q == SQ_RECOVER) ||
                          $past(state_q == SQ_RDBURST))); // R9

endmodule

// File: tb/test_ddr_burst_seq.sv
module test_ddr_burst_seq;

  localparam int BUS_W = 32;
  localparam int BEATS = 4;
  localparam int CYC   = BEATS / 2;
  localparam int TWR   = 3;

  localparam int M_IDLE = 0, M_CAS = 1, M_RD = 2, M_PRE = 3,
                 M_WR = 4, M_TWR = 5, M_DONE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cas_sel3 = 1'b0;
  logic pend_rd = 1'b0;
  logic pend_wr = 1'b0;
  logic [31:0] wr_word = 32'h1234_5678;
  logic [3:0]  wr_be = 4'h0;
  logic [15:0] rd_rise = 16'h0100;
  logic [15:0] rd_fall = 16'h0200;
  logic read_data_en, write_data_en, write_dqs_en, rd_word_vld, xfer_done;
  logic [15:0] dq_rise, dq_fall;
  logic [1:0]  dm_rise, dm_fall;
  logic [31:0] rd_word;

  int checks = 0;
  int errors = 0;

  ddr_burst_seq #(.BUS_W(BUS_W), .BURST_BEATS(BEATS), .TWR_CYC(TWR)) i_ddr_burst_seq (
    .clk(clk), .rst_n(rst_n), .cas_sel3(cas_sel3), .pend_rd(pend_rd), .pend_wr(pend_wr),
    .wr_word(wr_word), .wr_be(wr_be), .rd_rise(rd_rise), .rd_fall(rd_fall),
    .read_data_en(read_data_en), .write_data_en(write_data_en), .write_dqs_en(write_dqs_en),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise), .dm_fall(dm_fall),
    .rd_word(rd_word), .rd_word_vld(rd_word_vld), .xfer_done(xfer_done)
  );

  always #10 clk = ~clk;

  // free-running data sources, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    rd_rise = rd_rise + 16'h1357;
    rd_fall = (rd_fall ^ 16'hA5C3) + 16'h0001;
    wr_word = {wr_word[30:0], wr_word[31] ^ wr_word[21] ^ wr_word[1] ^ wr_word[0]};
    wr_be   = wr_be + 4'h5;
  end

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_mode = M_IDLE;
  int m_left = 0;
  logic        exp_vld = 1'b0;
  logic [31:0] exp_word = 32'h0;

  task automatic m_decide(input int from);
    if (pend_rd) begin
      if (from == M_RD) begin m_mode = M_RD; m_left = CYC; end
      else begin m_mode = M_CAS; m_left = cas_sel3 ? 3 : 2; end
    end else if (pend_wr) begin
      if (from == M_WR) begin m_mode = M_WR; m_left = CYC; end
      else m_mode = M_PRE;
    end else if (from == M_RD) m_mode = M_DONE;
    else if (from == M_WR) begin m_mode = M_TWR; m_left = TWR; end
    else m_mode = M_IDLE;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = M_IDLE; m_left = 0; exp_vld = 1'b0; exp_word = 32'h0;
    end else begin
      if (m_mode == M_RD) begin exp_vld = 1'b1; exp_word = {rd_rise, rd_fall}; end
      else exp_vld = 1'b0;
      case (m_mode)
        M_IDLE, M_DONE: m_decide(m_mode);
        M_CAS: if (m_left == 1) begin m_mode = M_RD; m_left = CYC; end else m_left--;
        M_RD:  if (m_left == 1) m_decide(M_RD); else m_left--;
        M_PRE: begin m_mode = M_WR; m_left = CYC; end
        M_WR:  if (m_left == 1) m_decide(M_WR); else m_left--;
        M_TWR: if (m_left == 1) m_mode = M_DONE; else m_left--;
        default: m_mode = M_IDLE;
      endcase
    end
  end

  // per-cycle comparison against the model, plus run/gap monitors
  int run_rd = 0, run_wr = 0, run_dqs = 0, run_done = 0;
  int last_rd = 0, last_wr = 0, last_dqs = 0, last_done = 0;
  int n_rden = 0, n_wren = 0;
  int since_wr = 100, since_rd = 100, gap_wr = 0, gap_rd = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic w;
      w = (m_mode == M_WR);
      check("R4", "read_data_en", {31'b0, read_data_en}, {31'b0, m_mode == M_RD});
      check("R6", "write_data_en", {31'b0, write_data_en}, {31'b0, w});
      check("R7", "write_dqs_en", {31'b0, write_dqs_en}, {31'b0, w || m_mode == M_PRE});
      check("R10", "xfer_done", {31'b0, xfer_done}, {31'b0, m_mode == M_DONE});
      check("R8", "dq pair", {dq_rise, dq_fall}, w ? wr_word : 32'h0);
      check("R8", "dm pair", {28'b0, dm_rise, dm_fall}, w ? {28'b0, ~wr_be} : 32'h0);
      check("R11", "rd_word_vld", {31'b0, rd_word_vld}, {31'b0, exp_vld});
      check("R11", "rd_word", rd_word, exp_word);

      if (read_data_en) begin run_rd++; n_rden++; since_rd = 0; end
      else begin if (run_rd > 0) last_rd = run_rd; run_rd = 0; since_rd++; end
      if (write_data_en) begin run_wr++; n_wren++; since_wr = 0; end
      else begin if (run_wr > 0) last_wr = run_wr; run_wr = 0; since_wr++; end
      if (write_dqs_en) run_dqs++;
      else begin if (run_dqs > 0) last_dqs = run_dqs; run_dqs = 0; end
      if (xfer_done) begin run_done++; gap_wr = since_wr; gap_rd = since_rd; end
      else begin if (run_done > 0) last_done = run_done; run_done = 0; end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic settle();
    repeat (14) tick();
  endtask

  task automatic clear_counts();
    n_rden = 0; n_wren = 0; last_rd = 0; last_wr = 0; last_dqs = 0; last_done = 0;
  endtask

  task automatic read_latency(input logic sel, output int n);
    cas_sel3 = sel; pend_rd = 1'b1; tick(); pend_rd = 1'b0;
    n = 0;
    @(negedge clk);
    while (!read_data_en && n < 10) begin n++; @(negedge clk); end
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    // R1: reset state
    repeat (3) tick();
    @(negedge clk);
    check("R1", "enables in reset",
          {27'b0, read_data_en, write_data_en, write_dqs_en, xfer_done, rd_word_vld}, 32'h0);
    check("R1", "data in reset", {dq_rise, dq_fall}, 32'h0);
    check("R1", "mask in reset", {28'b0, dm_rise, dm_fall}, 32'h0);
    check("R1", "rd_word in reset", rd_word, 32'h0);
    tick(); rst_n = 1'b1; tick();
    @(negedge clk);
    check("R1", "idle after release",
          {28'b0, read_data_en, write_data_en, write_dqs_en, xfer_done}, 32'h0);
    tick();

    // R3: CAS latency 2 and 3, R4 burst length, R10 done timing
    clear_counts();
    read_latency(1'b0, lat);
    check("R3", "latency CL2", lat, 2);
    settle();
    check("R4", "read burst length", last_rd, CYC);
    check("R10", "done width", last_done, 1);
    check("R10", "done after read", gap_rd, 1);
    read_latency(1'b1, lat);
    check("R3", "latency CL3", lat, 3);
    settle();

    // R5: chained reads without a gap
    clear_counts();
    cas_sel3 = 1'b0; pend_rd = 1'b1; tick(); pend_rd = 1'b0;
    while (!read_data_en) @(negedge clk);
    pend_rd = 1'b1;
    tick(); tick(); pend_rd = 1'b0;
    settle();
    check("R5", "chained read run", last_rd, 2 * CYC);

    // R6, R7, R9: single write
    clear_counts();
    pend_wr = 1'b1; tick(); pend_wr = 1'b0;
    settle();
    check("R6", "write burst length", last_wr, CYC);
    check("R7", "dqs window", last_dqs, CYC + 1);
    check("R9", "recovery gap", gap_wr, TWR + 1);

    // R6: chained writes keep one preamble
    clear_counts();
    pend_wr = 1'b1; tick(); tick(); tick();
    tick(); pend_wr = 1'b0;
    settle();
    check("R6", "chained write run", last_wr, 2 * CYC);
    check("R7", "chained dqs window", last_dqs, 2 * CYC + 1);

    // R9: write followed by read skips recovery; R6 read then write
    clear_counts();
    pend_wr = 1'b1; tick(); pend_wr = 1'b0; tick();
    pend_rd = 1'b1; tick(); tick(); pend_rd = 1'b0;
    settle();
    check("R9", "read after write", n_rden, CYC);
    clear_counts();
    pend_rd = 1'b1; tick(); pend_rd = 1'b0;
    while (!read_data_en) @(negedge clk);
    pend_wr = 1'b1; tick(); tick(); pend_wr = 1'b0;
    settle();
    check("R6", "write after read", n_wren, CYC);

    // R2: pend_wr pulsed inside latency wait is ignored
    clear_counts();
    cas_sel3 = 1'b1; pend_rd = 1'b1; tick(); pend_rd = 1'b0;
    pend_wr = 1'b1; tick(); pend_wr = 1'b0;
    settle();
    check("R2", "stray write flag", n_wren, 0);
    // R2: both flags together, read wins
    clear_counts();
    pend_rd = 1'b1; pend_wr = 1'b1; tick(); pend_rd = 1'b0; pend_wr = 1'b0;
    settle();
    check("R2", "priority write count", n_wren, 0);
    check("R2", "priority read count", n_rden, CYC);

    // R10: flag sampled during done starts a transfer
    clear_counts();
    cas_sel3 = 1'b0; pend_rd = 1'b1; tick(); pend_rd = 1'b0;
    while (!xfer_done) @(negedge clk);
    pend_wr = 1'b1; tick(); pend_wr = 1'b0;
    settle();
    check("R10", "restart from done", n_wren, CYC);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule